// File: doc/BRIEF.md
# Rotating DDR Read Capture

This block takes double-data-rate read data from a memory and moves it into the system clock domain. The strobe that comes with the data has already been delayed to the middle of the data eye. It toggles only while a read burst is on the wires. The words are registered on both strobe edges into four slots in turn. Even slots are written on rising edges and odd slots on falling edges. Because of this rotation, each word stays put for about two system cycles before its slot is reused.

Only one register stage runs on the strobe. Everything after it runs on the system clock. A toggle bit that flips each time an odd slot is written tells the system side when a rising/falling pair is complete. The system side then copies that pair, in capture order, into a small first-word-fall-through FIFO. The controller raises `rd_expect` for the duration of a read. While it is low and nothing is pending, all slot pointers return home.

Top module: `rd_capture_rotate`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0.
- R2: Consecutive words of a burst occupy slots 0, 1, 2, 3, 0, … in arrival order across both strobe edges, and the words leave the block in exactly that order.
- R3: Each output beat carries one rising-edge word and the following falling-edge word: bits [DW-1:0] hold the earlier (rising-edge) word and bits [2*DW-1:DW] hold the later (falling-edge) word.
- R4: Bursts of 2, 4 and 8 words are delivered as 1, 2 and 4 beats respectively, with no missing or extra beats.
- R5: While `rd_expect` is low and no captured pair is pending, both the strobe-side and the system-side pointers return to slot 0. The next burst therefore starts at slot 0 whatever the length of the previous one.
- R6: `out_valid` is high whenever the FIFO is not empty. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values. A beat is removed on a clock edge where both are high.
- R7: The FIFO holds FDEPTH beats. A pair that completes while the FIFO is full is dropped and the beats already stored are unaffected. `overflow` is then set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | Delayed read strobe, toggling only during bursts |
| rd_dq | input | DW | Read data, edge aligned with the undelayed strobe |
| rd_expect | input | 1 | Read in progress, from the controller (system clock domain) |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_data | output | 2*DW | Word pair, earlier word in the low half |
| out_valid | output | 1 | A beat is available |
| overflow | output | 1 | Sticky: a pair arrived while the FIFO was full |

## Verification
The hardest case to reach from the ports is a new burst that starts after a shorter one has left the pointers mid-rotation. Only the homing of R5 keeps the write and read sides aligned in that case. The stimulus mixes bursts of 2, 4 and 8 words in an order that leaves the system-side pair pointer at 1 before a longer burst. Each burst is drained only after it ends, so `out_ready` stays low while data arrives. Overflow is reached by filling the FIFO exactly with an 8-word burst and then sending a 2-word burst without draining.

// File: rtl/rd_capture_rotate.sv
module rd_capture_rotate #(
  parameter int DW     = 8,
  parameter int FDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic [DW-1:0] rd_dq,
  input  logic          rd_expect,
  input  logic          out_ready,
  output logic [2*DW-1:0] out_data,
  output logic          out_valid,
  output logic          overflow
);
  localparam int AW = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
  localparam int CW = $clog2(FDEPTH + 1);

  logic [DW-1:0] cap0, cap1, cap2, cap3;
  logic          wp_r, wp_f;
  logic [1:0]    tog;

  logic [1:0]    s_tog, seen;
  logic          rp, clr;
  logic [2*DW-1:0] mem [FDEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  always_ff @(posedge rd_strobe or posedge clr)
    if (clr) wp_r <= 1'b0;
    else     wp_r <= ~wp_r;

  always_ff @(posedge rd_strobe)
    if (!wp_r) cap0 <= rd_dq;
    else       cap2 <= rd_dq;

  always_ff @(negedge rd_strobe or posedge clr)
    if (clr) wp_f <= 1'b0;
    else     wp_f <= ~wp_f;

  always_ff @(negedge rd_strobe)
    if (!wp_f) cap1 <= rd_dq;
    else       cap3 <= rd_dq;

  always_ff @(negedge rd_strobe or negedge rst_n)
    if (!rst_n) tog <= 2'b00;
    else        tog[wp_f] <= ~tog[wp_f];

  logic            fresh, full, push, pop, idle_c;
  logic [2*DW-1:0] pair;

  assign fresh  = s_tog[rp] != seen[rp];
  assign pair   = rp ? {cap3, cap2} : {cap1, cap0};
  assign full   = count == CW'(FDEPTH);
  assign push   = fresh && !full;
  assign pop    = out_valid && out_ready;
  assign idle_c = !rd_expect && (s_tog == seen);

  assign out_valid = count != '0;
  assign out_data  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_tog    <= 2'b00;
      seen     <= 2'b00;
      rp       <= 1'b0;
      clr      <= 1'b1;
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      s_tog <= tog;
      clr   <= idle_c;
      if (fresh) begin
        seen[rp] <= ~seen[rp];
        rp       <= ~rp;
      end else if (idle_c) begin
        rp <= 1'b0;
      end
      if (fresh && full) overflow <= 1'b1;
      if (push) wptr <= (wptr == AW'(FDEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(FDEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= pair;

endmodule

// File: rtl/rdcap_chk.sv
module rdcap_chk #(
  parameter int DW     = 8,
  parameter int FDEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [2*DW-1:0]              out_data,
  input logic                         overflow,
  input logic [$clog2(FDEPTH+1)-1:0]  count,
  input logic                         fresh,
  input logic                         full,
  input logic                         clr,
  input logic                         push
);
  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(FDEPTH+1))'(FDEPTH));

  a_r7_rise_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(full && fresh));

  a_r5_quiet_when_home: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !push);
endmodule

bind rd_capture_rotate rdcap_chk #(.DW(DW), .FDEPTH(FDEPTH)) u_chk (.*);

// File: tb/sim_rd_capture_rotate.sv
`timescale 1ns/1ps
module sim_rd_capture_rotate;
  localparam int DW = 8;
  localparam int FDEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0, rd_strobe = 1'b0, rd_expect = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] rd_dq = '0;
  logic [2*DW-1:0] out_data;
  logic out_valid, overflow;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rd_capture_rotate #(.DW(DW), .FDEPTH(FDEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_dq(rd_dq),
    .rd_expect(rd_expect), .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid), .overflow(overflow));

  // {burst length, base word}
  localparam logic [11:0] VEC [5] = '{
    {4'd2, 8'h10}, {4'd8, 8'hA0}, {4'd2, 8'h3C}, {4'd4, 8'hF1}, {4'd8, 8'h07}};

  function automatic logic [DW-1:0] wv(input logic [DW-1:0] base, input int i);
    return base + DW'(i * 37);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic burst(input int len, input logic [DW-1:0] base);
    @(negedge clk) rd_expect = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < len; i += 2) begin
      rd_dq = wv(base, i);
      #1.25 rd_strobe = 1'b1;
      #1.25 rd_dq = wv(base, i + 1);
      #1.25 rd_strobe = 1'b0;
      #1.25;
    end
    rd_dq = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rd_expect = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // R2 R3 R4 R6: beats leave in capture order, earlier word low
  task automatic drain(input int len, input logic [DW-1:0] base);
    @(negedge clk);
    for (int n = 0; n < len / 2; n++) begin
      chk(out_valid === 1'b1, "R4 beat present", 32'(out_valid), 1);
      chk(out_data === {wv(base, 2*n+1), wv(base, 2*n)}, "R2/R3 beat order",
          32'(out_data), 32'({wv(base, 2*n+1), wv(base, 2*n)}));
      out_ready = 1'b1;
      @(negedge clk) out_ready = 1'b0;
    end
    chk(out_valid === 1'b0, "R4 no extra beat", 32'(out_valid), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 0);
    chk(overflow === 1'b0, "R1 reset overflow", 32'(overflow), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R5: mixed lengths leave the pair pointer mid-rotation before a longer burst
    for (int k = 0; k < 5; k++) begin
      burst(int'(VEC[k][11:8]), VEC[k][7:0]);
      drain(int'(VEC[k][11:8]), VEC[k][7:0]);
    end

    // R6: beat held while not accepted
    burst(2, 8'h55);
    repeat (5) @(negedge clk);
    chk(out_data === {wv(8'h55, 1), wv(8'h55, 0)}, "R6 hold",
        32'(out_data), 32'({wv(8'h55, 1), wv(8'h55, 0)}));
    drain(2, 8'h55);

    // R7: exact fill, then overflow
    burst(8, 8'hC3);
    @(negedge clk);
    chk(overflow === 1'b0, "R7 full no overflow", 32'(overflow), 0);
    burst(2, 8'h99);
    @(negedge clk);
    chk(overflow === 1'b1, "R7 overflow set", 32'(overflow), 1);
    drain(8, 8'hC3);
    chk(overflow === 1'b1, "R7 overflow sticky", 32'(overflow), 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk(overflow === 1'b0, "R1 overflow cleared", 32'(overflow), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    burst(4, 8'h6E);
    drain(4, 8'h6E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule